// File: doc/BRIEF.md
# First-order Taylor sine correction

This block sharpens a sinusoid sample that came from a coarse quarter-wave table. The table address holds only the integer part of the phase, so the sample belongs to a phase a little below the true one. The caller supplies the table sample (the value), the matching sample of its derivative, and the fractional phase that was dropped from the address. The block adds the derivative scaled by that dropped phase, which brings the result close to the sinusoid at the full phase. When a cosine is being corrected, its derivative is minus sine. A parameter then makes the block subtract the term, so the caller can pass the plain sine sample.

The correction runs in three registered steps. The first multiplies the phase error by a fixed-point pi/2 constant and trims the product. The second multiplies that product by the derivative sample. The third shifts the value up to the product's binary point, adds, rounds back to the sample scale and clamps to the output range. Samples enter and leave on valid/ready handshakes. While the output holds a sample that has not been taken, the whole pipeline freezes and `in_ready` is low. A sample is transferred on any clock edge where both valid and ready are high. Senders must hold their data steady until that edge.

Top module: `taylor_sine_corrector`

## Requirements
- R1: With the defaults (VAL_W=16, ERR_W=10, ADDR_W=8, PI_FRAC=16), let K=102944 and t=(in_err*K)>>3. `out_value` is then the clamp of floor((in_value*2^31 + in_deriv*t + 2^30) / 2^31). Here `in_value` and `in_deriv` are signed two's complement, and `in_err` is unsigned and stands for in_err/1024 of one table step.
- R2: With `out_ready` held high, a sample accepted on a clock edge appears with `out_valid` high after the third rising edge, counting the accepting edge.
- R3: With SUB_DERIV=1, the term in_deriv*t is subtracted instead of added. Everything else stays as in R1.
- R4: The result is clamped to the range -32768 to 32767. It never wraps, and its sign follows the sign of the unrounded sum.
- R5: When `in_err` is 0, `out_value` equals `in_value` exactly, whatever `in_deriv` is.
- R6: While `out_valid` is high and `out_ready` is low, `out_value` and `out_valid` hold and `in_ready` is low. An offered sample waits until the stall clears and then comes out with the correct value.
- R7: During and right after reset, `out_valid` is low and `in_ready` is high.
- R8: Suppose value and derivative are rounded samples of 32767*sin and 32767*cos at a table phase. The output is then within 3 LSB of 32767*sin at the full phase. For phase errors of half a step or more, it is also closer than the uncorrected value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block accepts a sample this cycle |
| in_value | input | VAL_W | Table sample at the truncated phase, signed |
| in_deriv | input | VAL_W | Derivative sample at the truncated phase, signed |
| in_err | input | ERR_W | Dropped fractional phase, unsigned |
| out_valid | output | 1 | Corrected sample present |
| out_ready | input | 1 | Consumer takes the sample this cycle |
| out_value | output | VAL_W | Corrected, rounded and clamped sample, signed |

## Verification
The assertions take for granted that reset is applied before any valid traffic and that `out_ready` is a plain level from the consumer. The sign checks on the final stage assume the aligned sum never exceeds its guard bit, which holds for any input pattern at the default widths. The stimulus drives full-scale values and derivatives of both signs, zero and maximum phase errors, and table samples of a real sine. It holds each offered sample steady until it is accepted, including through a stall of several cycles.

// File: rtl/taylor_pkg.sv
package taylor_pkg;
  localparam real HALF_PI = 1.5707963267948966;

  // pi/2 scaled by 2^frac and rounded to nearest
  function automatic int pi_half_fixed(input int frac);
    return $rtoi(HALF_PI * (2.0 ** frac) + 0.5);
  endfunction
endpackage

// File: rtl/taylor_err_scale.sv
module taylor_err_scale #(
  parameter int VAL_W   = 16,
  parameter int ERR_W   = 10,
  parameter int PI_FRAC = 16,
  parameter int TRIM    = 3,
  parameter int P1T_W   = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    in_v,
  input  logic signed [VAL_W-1:0] val_i,
  input  logic signed [VAL_W-1:0] der_i,
  input  logic [ERR_W-1:0]        err_i,
  output logic                    v_o,
  output logic signed [VAL_W-1:0] val_o,
  output logic signed [VAL_W-1:0] der_o,
  output logic [P1T_W-1:0]        scaled_o
);
  localparam int K_W  = PI_FRAC + 1;
  localparam int P1_W = ERR_W + K_W;
  localparam logic [K_W-1:0] K_CONST = K_W'(taylor_pkg::pi_half_fixed(PI_FRAC));

  logic [P1_W-1:0] prod;
  assign prod = P1_W'(err_i) * P1_W'(K_CONST);

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o      <= 1'b0;
      val_o    <= '0;
      der_o    <= '0;
      scaled_o <= '0;
    end else if (en) begin
      v_o      <= in_v;
      val_o    <= val_i;
      der_o    <= der_i;
      scaled_o <= P1T_W'(prod >> TRIM);
    end
  end

  assert_zero_err_R5: assert property (@(posedge clk) disable iff (rst)
    (en && in_v && err_i == '0) |=> (scaled_o == '0));
endmodule

// File: rtl/taylor_deriv_mult.sv
module taylor_deriv_mult #(
  parameter int VAL_W     = 16,
  parameter int P1T_W     = 24,
  parameter bit SUB_DERIV = 1'b0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          en,
  input  logic                          in_v,
  input  logic signed [VAL_W-1:0]       val_i,
  input  logic signed [VAL_W-1:0]       der_i,
  input  logic [P1T_W-1:0]              scaled_i,
  output logic                          v_o,
  output logic signed [VAL_W-1:0]       val_o,
  output logic signed [VAL_W+P1T_W:0]   term_o
);
  localparam int P2_W = VAL_W + P1T_W + 1;

  logic signed [P2_W-1:0] opa, opb, prod, term;
  assign opa  = P2_W'(der_i);
  assign opb  = P2_W'($signed({1'b0, scaled_i}));
  assign prod = opa * opb;

  generate
    if (SUB_DERIV) begin : g_sub
      assign term = -prod;
    end else begin : g_add
      assign term = prod;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o    <= 1'b0;
      val_o  <= '0;
      term_o <= '0;
    end else if (en) begin
      v_o    <= in_v;
      val_o  <= val_i;
      term_o <= term;
    end
  end
endmodule

// File: rtl/taylor_round_sat.sv
module taylor_round_sat #(
  parameter int VAL_W = 16,
  parameter int P2_W  = 41,
  parameter int SH    = 31
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    in_v,
  input  logic signed [VAL_W-1:0] val_i,
  input  logic signed [P2_W-1:0]  term_i,
  output logic                    v_o,
  output logic signed [VAL_W-1:0] q_o
);
  localparam int BASE_W = ((VAL_W + SH) > P2_W) ? (VAL_W + SH) : P2_W;
  localparam int SUM_W  = BASE_W + 1;
  localparam logic [SUM_W-1:0] HALF = SUM_W'(1) << (SH - 1);
  localparam logic signed [SUM_W-1:0] QMAX =
    {{(SUM_W-VAL_W+1){1'b0}}, {(VAL_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] QMIN =
    {{(SUM_W-VAL_W+1){1'b1}}, {(VAL_W-1){1'b0}}};

  logic signed [SUM_W-1:0] val_ext, val_sh, term_ext, sum, rnd;
  logic signed [VAL_W-1:0] clamped;

  assign val_ext  = SUM_W'(val_i);
  assign val_sh   = val_ext <<< SH;
  assign term_ext = SUM_W'(term_i);
  assign sum      = val_sh + term_ext;
  assign rnd      = (sum + $signed(HALF)) >>> SH;

  always_comb begin
    if (rnd > QMAX)      clamped = QMAX[VAL_W-1:0];
    else if (rnd < QMIN) clamped = QMIN[VAL_W-1:0];
    else                 clamped = rnd[VAL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o <= 1'b0;
      q_o <= '0;
    end else if (en) begin
      v_o <= in_v;
      q_o <= clamped;
    end
  end

  assert_pos_no_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (en && in_v && !sum[SUM_W-1]) |=> !q_o[VAL_W-1]);
  assert_neg_no_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (en && in_v && sum[SUM_W-1]) |=> (q_o[VAL_W-1] || q_o == '0));
endmodule

// File: rtl/taylor_sine_corrector.sv
module taylor_sine_corrector #(
  parameter int VAL_W     = 16,
  parameter int ERR_W     = 10,
  parameter int ADDR_W    = 8,
  parameter int PI_FRAC   = 16,
  parameter int MUL_A_MAX = 25,
  parameter bit SUB_DERIV = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VAL_W-1:0] in_value,
  input  logic [VAL_W-1:0] in_deriv,
  input  logic [ERR_W-1:0] in_err,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VAL_W-1:0] out_value
);
  localparam int K_W   = PI_FRAC + 1;
  localparam int P1_W  = ERR_W + K_W;
  localparam int TRIM  = (P1_W > MUL_A_MAX - 1) ? (P1_W - (MUL_A_MAX - 1)) : 0;
  localparam int P1T_W = P1_W - TRIM;
  localparam int P2_W  = VAL_W + P1T_W + 1;
  localparam int SH    = ERR_W + PI_FRAC - TRIM + ADDR_W;

  logic en;
  logic v1, v2;
  logic signed [VAL_W-1:0] val1, der1, val2, q;
  logic [P1T_W-1:0] scaled1;
  logic signed [P2_W-1:0] term2;

  assign en       = out_ready || !out_valid;
  assign in_ready = en;

  taylor_err_scale #(
    .VAL_W(VAL_W), .ERR_W(ERR_W), .PI_FRAC(PI_FRAC), .TRIM(TRIM), .P1T_W(P1T_W)
  ) u_scale (
    .clk(clk), .rst(rst), .en(en), .in_v(in_valid),
    .val_i($signed(in_value)), .der_i($signed(in_deriv)), .err_i(in_err),
    .v_o(v1), .val_o(val1), .der_o(der1), .scaled_o(scaled1)
  );

  taylor_deriv_mult #(
    .VAL_W(VAL_W), .P1T_W(P1T_W), .SUB_DERIV(SUB_DERIV)
  ) u_mult (
    .clk(clk), .rst(rst), .en(en), .in_v(v1),
    .val_i(val1), .der_i(der1), .scaled_i(scaled1),
    .v_o(v2), .val_o(val2), .term_o(term2)
  );

  taylor_round_sat #(
    .VAL_W(VAL_W), .P2_W(P2_W), .SH(SH)
  ) u_round (
    .clk(clk), .rst(rst), .en(en), .in_v(v2),
    .val_i(val2), .term_i(term2),
    .v_o(out_valid), .q_o(q)
  );

  assign out_value = q;

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_value)));
  assert_flow_R2: assert property (@(posedge clk) disable iff (rst)
    (in_ready && v2) |=> out_valid);
endmodule

// File: tb/taylor_sine_corrector_tb.sv
module taylor_sine_corrector_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [15:0] in_value = '0, in_deriv = '0;
  logic [9:0]  in_err = '0;
  logic in_ready, out_valid, in_ready_s, out_valid_s;
  logic [15:0] out_value, out_value_s;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  taylor_sine_corrector u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_value(in_value), .in_deriv(in_deriv), .in_err(in_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_value(out_value));

  taylor_sine_corrector #(.SUB_DERIV(1'b1)) u_dut_sub (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready_s),
    .in_value(in_value), .in_deriv(in_deriv), .in_err(in_err),
    .out_valid(out_valid_s), .out_ready(out_ready), .out_value(out_value_s));

  localparam int VEC [8][3] = '{
    '{1000, 2000, 0}, '{1000, 0, 777}, '{0, 32767, 1023}, '{-5000, 12000, 512},
    '{20000, -15000, 300}, '{32767, 32767, 1023}, '{-32768, 32767, 1023},
    '{-32768, -32767, 1023}};

  function automatic longint model(int v, int d, int e, bit sub);
    longint t, p, s, r;
    t = (longint'(e) * 102944) >>> 3;
    p = longint'(d) * t;
    s = sub ? (longint'(v) * (64'sd1 <<< 31) - p) : (longint'(v) * (64'sd1 <<< 31) + p);
    r = (s + (64'sd1 <<< 30)) >>> 31;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  function automatic int rnd_int(real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : $rtoi(x - 0.5);
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(int v, int d, int e, output longint ra, output longint rs, output int lat);
    @(negedge clk);
    in_value = 16'(v); in_deriv = 16'(d); in_err = 10'(e); in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    ra = longint'($signed(out_value));
    rs = longint'($signed(out_value_s));
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint ra, rs, a0;
    int lat;
    int unsigned seed = 32'h1234_5678;
    real bstep, truth, errc, erru;

    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R7 out_valid in reset", out_valid, 0);
    chk("R7 in_ready in reset", in_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R7 out_valid after reset", out_valid, 0);
    chk("R7 in_ready after reset", in_ready, 1);

    // table walk: R1 add, R3 subtract, R2 latency
    for (int i = 0; i < 8; i++) begin
      send(VEC[i][0], VEC[i][1], VEC[i][2], ra, rs, lat);
      chk("R2 latency", lat, 3);
      chk("R1 add result", ra, model(VEC[i][0], VEC[i][1], VEC[i][2], 1'b0));
      chk("R3 subtract result", rs, model(VEC[i][0], VEC[i][1], VEC[i][2], 1'b1));
    end

    // R5: zero error passes value through
    send(-12345, -32768, 0, ra, rs, lat);
    chk("R5 zero err add", ra, -12345);
    chk("R5 zero err sub", rs, -12345);

    // R4: saturation at both ends
    send(32767, 32767, 1023, ra, rs, lat);
    chk("R4 clamp high", ra, 32767);
    send(-32768, -32767, 1023, ra, rs, lat);
    chk("R4 clamp low add", ra, -32768);
    send(-32768, 32767, 1023, ra, rs, lat);
    chk("R4 clamp low sub", rs, -32768);

    // R6: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    send(3000, 20000, 900, ra, rs, lat);
    a0 = ra;
    chk("R6 first item", a0, model(3000, 20000, 900, 1'b0));
    in_value = 16'(-7000); in_deriv = 16'(-9000); in_err = 10'd600; in_valid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R6 valid held", out_valid, 1);
      chk("R6 value held", longint'($signed(out_value)), a0);
      chk("R6 in_ready low", in_ready, 0);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk("R6 second item latency", lat, 3);
    chk("R6 second item", longint'($signed(out_value)), model(-7000, -9000, 600, 1'b0));

    // R8: accuracy against a real sine
    bstep = 1.5707963267948966 / 256.0;
    for (int n = 0; n < 40; n++) begin
      int ai, ei, vv, dd;
      seed = seed * 32'd1664525 + 32'd1013904223;
      ai = int'((seed >> 4) % 201);
      ei = int'((seed >> 16) % 1024);
      vv = rnd_int(32767.0 * $sin(ai * bstep));
      dd = rnd_int(32767.0 * $cos(ai * bstep));
      truth = 32767.0 * $sin((ai + ei / 1024.0) * bstep);
      send(vv, dd, ei, ra, rs, lat);
      errc = (ra - truth) < 0.0 ? truth - ra : ra - truth;
      erru = (vv - truth) < 0.0 ? truth - vv : vv - truth;
      total++;
      if (errc > 3.0) begin
        bad++;
        $display("FAIL R8 error actual=%f expected<=3.0", errc);
      end
      if (ei >= 512) begin
        total++;
        if (!(errc < erru)) begin
          bad++;
          $display("FAIL R8 improvement actual=%f expected<%f", errc, erru);
        end
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule